// File: doc/BRIEF.md
# Ethernet Controller Interrupt Status Register

This block holds the interrupt status word of an Ethernet controller. It collects single-cycle event pulses from the receive DMA engine, the transmit FIFO logic, the general-purpose timer, the EEPROM programmer and the bus interface. It also presents two live levels: the receive DMA idle state and the external PHY interrupt. A host reads the status word and a companion enable mask through a plain register read/write port, and a single summary interrupt line tells the host that an enabled status bit is up.

Status bits follow different clearing rules. Most event bits latch and are cleared by writing one to their position. The transmit-early bit sets when a whole frame has been loaded into the transmit FIFO and clears by itself when that frame has drained. The PHY bit is a read-only mirror of an external register, so it falls when that register is read elsewhere. The receive-idle bit follows the engine state directly. A three-bit bus error type code is captured next to the bus error flag. Bit positions are fixed because host software decodes them.

Top module: `eth_irq_status`

## Requirements
- R1: After reset, the status word (host_sel=0) and the mask word (host_sel=1) read zero while phy_irq_lvl and rx_dma_idle are low, and irq_out is low.
- R2: The latched event bits (14 pause received, 13 bus error, 11 timer expired, 9 EEPROM write-protect fail, 7 receive buffer unavailable, 6 receive done, 5 transmit underflow) go high at the clock edge that samples their event pulse and stay high. A host write with host_sel=0 clears each of these bits whose host_wdata bit is one. A zero in host_wdata leaves the bit unchanged.
- R3: When a set pulse and a clearing write reach the same latched bit in the same cycle, the bit is high after that edge.
- R4: A bus error pulse captures bus_err_code into status bits 25:23 at the same edge. The code holds until the next bus error, and host writes do not change it.
- R5: Status bit 12 equals phy_irq_lvl in the same cycle. Host writes have no effect on it.
- R6: Status bit 8 equals rx_dma_idle in the same cycle. Host writes have no effect on it.
- R7: Status bit 10 sets at the edge that samples ev_tx_loaded, but only if tx_early_en is high in that cycle.
- R8: Status bit 10 clears at the edge that samples ev_tx_drained. Host writes do not change it. A qualified load in the same cycle as a drain leaves it set.
- R9: A host write with host_sel=1 stores host_wdata bits 14:5 into the mask, and the mask reads back at host_sel=1. All other mask bits read zero.
- R10: irq_out is high in the cycle after the cycle in which the AND of the status view and the mask has any bit set, and low otherwise.
- R11: Status bits 31:26, 22:15 and 4:0 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Register select: 0 status, 1 mask |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the selected register (combinational) |
| ev_pause_rx | input | 1 | Pulse: pause control frame received |
| ev_bus_err | input | 1 | Pulse: bus error |
| bus_err_code | input | 3 | Bus error type that goes with ev_bus_err |
| phy_irq_lvl | input | 1 | Level from the PHY's global interrupt status |
| ev_timer_exp | input | 1 | Pulse: general-purpose timer expired |
| tx_early_en | input | 1 | Transmit-early interrupt enable |
| ev_tx_loaded | input | 1 | Pulse: whole frame moved into the transmit FIFO |
| ev_tx_drained | input | 1 | Pulse: that frame fully sent out of the transmit FIFO |
| ev_eeprom_wp_fail | input | 1 | Pulse: write attempted to a write-protected EEPROM |
| rx_dma_idle | input | 1 | Level: receive DMA state machine is idle |
| ev_rx_no_buf | input | 1 | Pulse: no receive buffer available |
| ev_rx_done | input | 1 | Pulse: frame received and its descriptor written back |
| ev_tx_underflow | input | 1 | Pulse: transmit FIFO underflow |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A hardware event and a host clearing write can hit the same status bit in the same cycle, and so can a transmit-frame load and a transmit drain on bit 10. Directed steps drive each pair together and read the bit after the edge. The result must be set in both cases. Random stimulus then fires events and write-one-to-clear words at a high rate, so that many more coincidences occur. Every cycle is judged against a bench model that gives the set pulse priority.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
   // Bit positions decoded by host software.
   localparam int P_TUF    = 5;
   localparam int P_RXDONE = 6;
   localparam int P_NOBUF  = 7;
   localparam int P_RXIDLE = 8;
   localparam int P_EEFAIL = 9;
   localparam int P_TXE    = 10;
   localparam int P_TIMER  = 11;
   localparam int P_PHY    = 12;
   localparam int P_BUSERR = 13;
   localparam int P_PAUSE  = 14;
   localparam int P_TOP    = 14;

   localparam int N_W1C = 7;
   localparam int W1C_POS [N_W1C] = '{P_PAUSE, P_BUSERR, P_TIMER, P_EEFAIL,
                                      P_NOBUF, P_RXDONE, P_TUF};
endpackage

// File: rtl/isr_w1c_bit.sv
module isr_w1c_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/isr_txe_bit.sv
module isr_txe_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic early_en_i,
   input  logic loaded_i,
   input  logic drained_i,
   output logic q_o
);
   logic arm;
   assign arm = loaded_i && early_en_i;

   always_ff @(posedge clk) begin
      if (!rst_n)         q_o <= 1'b0;
      else if (arm)       q_o <= 1'b1;
      else if (drained_i) q_o <= 1'b0;
   end

   assert_load_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loaded_i && early_en_i) |=> q_o);
   assert_drain_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drained_i && !(loaded_i && early_en_i)) |=> !q_o);
   assert_txe_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!drained_i && !(loaded_i && early_en_i)) |=> $stable(q_o));
endmodule

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
   parameter int                 W        = 32,
   parameter logic [W-1:0]       WR_BITS  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)    mask_o <= '0;
      else if (wr_i) mask_o <= wdata_i & WR_BITS;
   end

   assert_mask_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (mask_o == ($past(wdata_i) & WR_BITS)));
   assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/isr_summary.sv
module isr_summary #(
   parameter int W         = 32,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stat_i,
   input  logic [W-1:0] mask_i,
   output logic         irq_o
);
   logic any_hit;
   assign any_hit = |(stat_i & mask_i);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= any_hit;
         end
         assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (|(stat_i & mask_i)) |=> irq_o);
         assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(|(stat_i & mask_i)) |=> !irq_o);
      end else begin : g_comb
         assign irq_o = any_hit;
      end
   endgenerate
endmodule

// File: rtl/eth_irq_status.sv
module eth_irq_status
   import eth_irq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CODE_W      = 3,
   parameter int CODE_LSB    = 23,
   parameter bit SUMMARY_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_sel,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              ev_pause_rx,
   input  logic              ev_bus_err,
   input  logic [CODE_W-1:0] bus_err_code,
   input  logic              phy_irq_lvl,
   input  logic              ev_timer_exp,
   input  logic              tx_early_en,
   input  logic              ev_tx_loaded,
   input  logic              ev_tx_drained,
   input  logic              ev_eeprom_wp_fail,
   input  logic              rx_dma_idle,
   input  logic              ev_rx_no_buf,
   input  logic              ev_rx_done,
   input  logic              ev_tx_underflow,
   output logic              irq_out
);
   localparam int N_MASK = P_TOP - P_TUF + 1;
   localparam logic [DATA_W-1:0] MASK_WR =
      {{(DATA_W-N_MASK){1'b0}}, {N_MASK{1'b1}}} << P_TUF;

   generate
      if (DATA_W < P_TOP + 1)              begin : g_bad_w    $error("DATA_W too small for status bits"); end
      if (CODE_LSB <= P_TOP)               begin : g_bad_lsb  $error("error code overlaps status bits"); end
      if (CODE_LSB + CODE_W > DATA_W)      begin : g_bad_code $error("error code exceeds DATA_W"); end
   endgenerate

   logic                 stat_wr, mask_wr;
   logic [N_W1C-1:0]     w1c_set, w1c_q;
   logic                 txe_q;
   logic [CODE_W-1:0]    code_q;
   logic [DATA_W-1:0]    mask_q, stat_view;

   assign stat_wr = host_wr && !host_sel;
   assign mask_wr = host_wr &&  host_sel;

   // Order follows W1C_POS in the package.
   assign w1c_set[0] = ev_pause_rx;
   assign w1c_set[1] = ev_bus_err;
   assign w1c_set[2] = ev_timer_exp;
   assign w1c_set[3] = ev_eeprom_wp_fail;
   assign w1c_set[4] = ev_rx_no_buf;
   assign w1c_set[5] = ev_rx_done;
   assign w1c_set[6] = ev_tx_underflow;

   generate
      for (genvar gi = 0; gi < N_W1C; gi++) begin : g_w1c
         isr_w1c_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (w1c_set[gi]),
            .clr_i (stat_wr && host_wdata[W1C_POS[gi]]),
            .q_o   (w1c_q[gi])
         );
      end
   endgenerate

   isr_txe_bit u_txe (
      .clk        (clk),
      .rst_n      (rst_n),
      .early_en_i (tx_early_en),
      .loaded_i   (ev_tx_loaded),
      .drained_i  (ev_tx_drained),
      .q_o        (txe_q)
   );

   // Bus error type capture.
   always_ff @(posedge clk) begin
      if (!rst_n)          code_q <= '0;
      else if (ev_bus_err) code_q <= bus_err_code;
   end

   assert_code_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_bus_err |=> (host_sel || host_rdata[CODE_LSB +: CODE_W] == $past(bus_err_code)));
   assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_bus_err |=> $stable(code_q));

   isr_mask_reg #(.W(DATA_W), .WR_BITS(MASK_WR)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mask_wr),
      .wdata_i (host_wdata),
      .mask_o  (mask_q)
   );

   always_comb begin
      stat_view = '0;
      for (int i = 0; i < N_W1C; i++) stat_view[W1C_POS[i]] = w1c_q[i];
      stat_view[P_TXE]    = txe_q;
      stat_view[P_PHY]    = phy_irq_lvl;
      stat_view[P_RXIDLE] = rx_dma_idle;
      stat_view[CODE_LSB +: CODE_W] = code_q;
   end

   assign host_rdata = host_sel ? mask_q : stat_view;

   isr_summary #(.W(DATA_W), .REGISTERED(SUMMARY_REG)) u_sum (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat_view),
      .mask_i (mask_q),
      .irq_o  (irq_out)
   );
endmodule

// File: tb/tb_eth_irq_status.sv
`timescale 1ns/1ps
module tb_eth_irq_status;
   localparam logic [31:0] W1C_BITS = 32'h0000_6AE0;
   localparam logic [31:0] MASK_WR  = 32'h0000_7FE0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_wr = 0, host_sel = 0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic ev_pause_rx = 0, ev_bus_err = 0, phy_irq_lvl = 0, ev_timer_exp = 0;
   logic [2:0] bus_err_code = '0;
   logic tx_early_en = 0, ev_tx_loaded = 0, ev_tx_drained = 0, ev_eeprom_wp_fail = 0;
   logic rx_dma_idle = 0, ev_rx_no_buf = 0, ev_rx_done = 0, ev_tx_underflow = 0;
   logic irq_out;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [31:0] m_lat = '0, m_mask = '0;
   logic        m_tx = 0, m_irq = 0;
   logic [2:0]  m_code = '0;

   always #2 clk = ~clk;

   eth_irq_status dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .ev_pause_rx(ev_pause_rx), .ev_bus_err(ev_bus_err), .bus_err_code(bus_err_code),
      .phy_irq_lvl(phy_irq_lvl), .ev_timer_exp(ev_timer_exp), .tx_early_en(tx_early_en),
      .ev_tx_loaded(ev_tx_loaded), .ev_tx_drained(ev_tx_drained),
      .ev_eeprom_wp_fail(ev_eeprom_wp_fail), .rx_dma_idle(rx_dma_idle),
      .ev_rx_no_buf(ev_rx_no_buf), .ev_rx_done(ev_rx_done),
      .ev_tx_underflow(ev_tx_underflow), .irq_out(irq_out));

   function automatic logic [31:0] exp_view();
      logic [31:0] v;
      v = m_lat;
      v[10] = m_tx;
      v[12] = phy_irq_lvl;
      v[8]  = rx_dma_idle;
      v[25:23] = m_code;
      return v;
   endfunction

   function automatic logic [31:0] exp_set();
      logic [31:0] s = '0;
      s[14] = ev_pause_rx;  s[13] = ev_bus_err;    s[11] = ev_timer_exp;
      s[9]  = ev_eeprom_wp_fail; s[7] = ev_rx_no_buf; s[6] = ev_rx_done;
      s[5]  = ev_tx_underflow;
      return s;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic clear_inputs();
      host_wr = 0; ev_pause_rx = 0; ev_bus_err = 0; ev_timer_exp = 0;
      ev_tx_loaded = 0; ev_tx_drained = 0; ev_eeprom_wp_fail = 0;
      ev_rx_no_buf = 0; ev_rx_done = 0; ev_tx_underflow = 0;
   endtask

   // Inputs already set after a falling edge; check, clock, update model.
   task automatic step(input string tag);
      logic [31:0] clr;
      logic        nirq;
      #1;
      check({tag, " read"}, host_rdata, host_sel ? m_mask : exp_view());
      check({tag, " irq"}, {31'd0, irq_out}, {31'd0, m_irq});
      @(posedge clk);
      clr  = (host_wr && !host_sel) ? (host_wdata & W1C_BITS) : '0;
      nirq = |(exp_view() & m_mask);
      m_lat = (m_lat & ~clr) | exp_set();
      if (ev_tx_loaded && tx_early_en) m_tx = 1'b1;
      else if (ev_tx_drained)          m_tx = 1'b0;
      if (ev_bus_err) m_code = bus_err_code;
      if (host_wr && host_sel) m_mask = host_wdata & MASK_WR;
      m_irq = nirq;
      @(negedge clk);
      clear_inputs();
   endtask

   task automatic wr_stat(input logic [31:0] d);
      host_wr = 1; host_sel = 0; host_wdata = d;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      // R1: reset values
      host_sel = 0; #1; check("R1 status", host_rdata, 32'h0);
      host_sel = 1; #1; check("R1 mask", host_rdata, 32'h0);
      check("R1 irq", {31'd0, irq_out}, 32'h0);
      @(negedge clk); rst_n = 1; host_sel = 0;

      // R2: events latch, writes of zero keep them, writes of one clear
      ev_pause_rx = 1; ev_timer_exp = 1; ev_rx_done = 1; step("R2 set");
      step("R2 hold");
      wr_stat(32'h0); step("R2 write zero");
      wr_stat(32'h0000_0800); step("R2 clear one bit");
      ev_eeprom_wp_fail = 1; ev_rx_no_buf = 1; ev_tx_underflow = 1; step("R2 set more");
      wr_stat(32'hFFFF_FFFF); step("R2 clear all");
      step("R11 unused bits zero after all-ones write");
      // R3: set and clear together
      ev_rx_no_buf = 1; wr_stat(32'h0000_0080); step("R3 same cycle");
      step("R3 after");
      ev_pause_rx = 1; wr_stat(32'h0000_4000); step("R3 pause same cycle");
      step("R3 after pause");
      // R4: bus error code
      ev_bus_err = 1; bus_err_code = 3'b101; step("R4 capture");
      wr_stat(32'hFFFF_FFFF); step("R4 write no effect");
      bus_err_code = 3'b010; step("R4 hold without event");
      ev_bus_err = 1; bus_err_code = 3'b011; wr_stat(32'h0000_2000); step("R4 recapture");
      step("R4 after");
      // R5 / R6: live bits
      phy_irq_lvl = 1; step("R5 phy high");
      wr_stat(32'h0000_1000); step("R5 write no effect");
      phy_irq_lvl = 0; step("R5 phy low");
      rx_dma_idle = 1; wr_stat(32'h0000_0100); step("R6 idle high");
      rx_dma_idle = 0; step("R6 idle low");
      // R7 / R8: transmit early bit
      tx_early_en = 0; ev_tx_loaded = 1; step("R7 load disabled");
      step("R7 after disabled");
      tx_early_en = 1; ev_tx_loaded = 1; step("R7 load enabled");
      wr_stat(32'hFFFF_FFFF); step("R8 write no effect");
      ev_tx_drained = 1; ev_tx_loaded = 1; step("R8 load and drain");
      step("R8 after overlap");
      ev_tx_drained = 1; step("R8 drain");
      step("R8 after drain");
      // R9: mask
      host_wr = 1; host_sel = 1; host_wdata = 32'hFFFF_FFFF; step("R9 mask write");
      host_sel = 1; step("R9 mask read");
      host_sel = 0;
      // R10: summary interrupt
      host_wr = 1; host_sel = 1; host_wdata = 32'h0000_0020; step("R10 mask tuf");
      ev_timer_exp = 1; step("R10 masked event");
      step("R10 no irq");
      ev_tx_underflow = 1; step("R10 enabled event");
      step("R10 irq up");
      wr_stat(32'h0000_0020); step("R10 clear");
      step("R10 irq down");
      host_sel = 0;

      // Random phase
      for (int n = 0; n < 4000; n++) begin
         ev_pause_rx       = ($urandom % 4) == 0;
         ev_bus_err        = ($urandom % 6) == 0;
         bus_err_code      = 3'($urandom);
         ev_timer_exp      = ($urandom % 4) == 0;
         ev_eeprom_wp_fail = ($urandom % 5) == 0;
         ev_rx_no_buf      = ($urandom % 4) == 0;
         ev_rx_done        = ($urandom % 3) == 0;
         ev_tx_underflow   = ($urandom % 5) == 0;
         ev_tx_loaded      = ($urandom % 4) == 0;
         ev_tx_drained     = ($urandom % 4) == 0;
         tx_early_en       = ($urandom % 3) != 0;
         if (($urandom % 8) == 0) phy_irq_lvl = ~phy_irq_lvl;
         if (($urandom % 8) == 0) rx_dma_idle = ~rx_dma_idle;
         host_wr    = ($urandom % 3) == 0;
         host_sel   = ($urandom % 5) == 0;
         host_wdata = (($urandom % 4) == 0) ? 32'hFFFF_FFFF : $urandom;
         step("R3 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule